// File: doc/BRIEF.md
# Master-Slave Scan Chain Clock Sequencer

This block controls a serial chain of shift-register stages. Each stage is a master latch followed by a slave latch. The controller drives three clock enables that never overlap:

- a scan clock A, which loads the serial input into each master;
- a slave clock B, which copies each master into its slave;
- a system clock C, which captures functional response data into the masters.

It also raises a one-cycle strobe to apply the primary inputs and another to sample the primary outputs. A behavioural model of the N-stage chain sits inside the top module, so the whole sequence can be seen at the ports.

One accepted start request runs one complete pattern. The steps, in order:

1. Load the pattern serially with N A-then-B pairs.
2. Apply the primary inputs.
3. Measure the primary outputs while every clock is off.
4. Capture the response with one C pulse.
5. Copy master to slave with a single B pulse.
6. Unload the chain with N further A-then-B pairs while zeros are shifted in.

The serial response is gathered into a parallel word that is presented when the run ends.

Every clock pulse lasts one controller cycle and is followed by at least one cycle with all clocks off. A run therefore takes a fixed 8N+8 cycles.

Top module: `scan_clk_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, a_en, b_en, c_en, pi_apply, po_sample, busy, done, scan_in, slave_q and unload_pat are all zero.
- R2: In no cycle is more than one of a_en, b_en and c_en high.
- R3: Each cycle with a_en, b_en or c_en high is followed by a cycle in which all three are low.
- R4: A run issues exactly 2N A pulses. The first N carry load_pat bit N-1 down to bit 0, one bit per pair on scan_in, so that slave stage i holds load_pat[i] after loading. The pattern is taken from load_pat at the accepted start.
- R5: After loading, pi_apply is high for exactly one cycle. Then po_sample is high for exactly one cycle with all clocks low, and in that cycle slave_q equals the loaded pattern.
- R6: After po_sample, exactly one C pulse captures func_d into the masters. It is followed by one lone B pulse, so a run has 2N+1 B pulses in total, and no C pulse occurs before po_sample.
- R7: Unloading shifts slave stage N-1 out first. scan_out is sampled in the idle cycle before each unload A pulse. At the end of the run, unload_pat[i] equals the func_d[i] value that was captured, and slave_q is all zeros.
- R8: busy is high for exactly 8N+8 cycles, beginning in the cycle after the accepting clock edge. done is high for exactly one cycle: the first cycle in which busy is low again.
- R9: A start request made while busy is high is ignored. It neither lengthens the run nor changes the pattern being loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one pattern; accepted only when idle |
| load_pat | input | N | Pattern to place in the slave latches |
| func_d | input | N | Functional response presented to the master capture ports |
| a_en | output | 1 | Scan clock enable (serial data into masters) |
| b_en | output | 1 | Slave clock enable (master copied to slave) |
| c_en | output | 1 | System clock enable (functional capture into masters) |
| pi_apply | output | 1 | One-cycle strobe to apply primary input stimulus |
| po_sample | output | 1 | One-cycle strobe to measure primary outputs |
| scan_in | output | 1 | Serial bit fed to the chain head |
| scan_out | output | 1 | Slave output of the last stage |
| slave_q | output | N | Slave latch contents of all stages |
| unload_pat | output | N | Response word gathered from scan_out |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The sequence is tried with several kinds of pattern pairs:

- all-zero and all-one patterns, which show up stuck or missing shifts;
- alternating patterns, which reveal a swapped bit order or an off-by-one shift;
- walking-one patterns, which locate a single misrouted stage;
- seeded random pairs, which mix all of these.

Because the pattern and the response always differ, a missing capture or a missing copy pulse leaves the load pattern where the response should be, and the two can be told apart. Some runs raise a second start with an inverted pattern while busy. A run that restarted or reloaded would then show a wrong length or the inverted value at the measure strobe.

// File: rtl/scan_clk_seq_pkg.sv
package scan_clk_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_APPLY,
    ST_MEAS,
    ST_CAPT,
    ST_COPY,
    ST_UNLD
  } seq_state_e;

  // Sub-steps inside one A/B pair; single-pulse phases use only the first two.
  localparam logic [1:0] SUB_A    = 2'd0;
  localparam logic [1:0] SUB_GAP1 = 2'd1;
  localparam logic [1:0] SUB_B    = 2'd2;
  localparam logic [1:0] SUB_GAP2 = 2'd3;

endpackage

// File: rtl/scan_step_fsm.sv
module scan_step_fsm
  import scan_clk_seq_pkg::*;
#(
  parameter int N  = 8,
  parameter int KW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          take,
  output logic          si_load,
  output logic [KW-1:0] si_idx,
  output logic          a_en,
  output logic          b_en,
  output logic          c_en,
  output logic          pi_apply,
  output logic          po_sample,
  output logic          busy,
  output logic          done
);

  localparam logic [KW-1:0] LAST = KW'(N - 1);
  localparam int CW = $clog2(2 * N + 1) + 1;

  seq_state_e    st, nst;
  logic [1:0]    sub, nsub;
  logic [KW-1:0] k, nk;
  logic          pair_n;

  assign accept = (st == ST_IDLE) && start;
  // Sample the tail slave in the idle cycle that precedes each unload A pulse.
  assign take   = ((st == ST_COPY) && (sub == SUB_GAP1)) ||
                  ((st == ST_UNLD) && (sub == SUB_GAP2) && (k != LAST));

  always_comb begin
    nst  = st;
    nsub = sub;
    nk   = k;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          nst  = ST_LOAD;
          nsub = SUB_A;
          nk   = '0;
        end
      end
      ST_LOAD, ST_UNLD: begin
        if (sub == SUB_GAP2) begin
          nsub = SUB_A;
          if (k == LAST) begin
            nk  = '0;
            nst = (st == ST_LOAD) ? ST_APPLY : ST_IDLE;
          end else begin
            nk = k + KW'(1);
          end
        end else begin
          nsub = sub + 2'd1;
        end
      end
      ST_APPLY, ST_MEAS, ST_CAPT, ST_COPY: begin
        if (sub == SUB_A) begin
          nsub = SUB_GAP1;
        end else begin
          nsub = SUB_A;
          case (st)
            ST_APPLY: nst = ST_MEAS;
            ST_MEAS:  nst = ST_CAPT;
            ST_CAPT:  nst = ST_COPY;
            default:  nst = ST_UNLD;
          endcase
        end
      end
      default: begin
        nst  = ST_IDLE;
        nsub = SUB_A;
        nk   = '0;
      end
    endcase
  end

  assign pair_n  = (nst == ST_LOAD) || (nst == ST_UNLD);
  assign si_load = (st != ST_IDLE) && (nst == ST_LOAD) && (nsub == SUB_A);
  assign si_idx  = LAST - nk;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sub       <= SUB_A;
      k         <= '0;
      a_en      <= 1'b0;
      b_en      <= 1'b0;
      c_en      <= 1'b0;
      pi_apply  <= 1'b0;
      po_sample <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      st        <= nst;
      sub       <= nsub;
      k         <= nk;
      a_en      <= pair_n && (nsub == SUB_A);
      b_en      <= (pair_n && (nsub == SUB_B)) ||
                   ((nst == ST_COPY) && (nsub == SUB_A));
      c_en      <= (nst == ST_CAPT) && (nsub == SUB_A);
      pi_apply  <= (nst == ST_APPLY) && (nsub == SUB_A);
      po_sample <= (nst == ST_MEAS) && (nsub == SUB_A);
      busy      <= (nst != ST_IDLE);
      done      <= (st == ST_UNLD) && (sub == SUB_GAP2) && (k == LAST);
    end
  end

  // Pulse tally used only by the checks below.
  logic [CW-1:0] a_cnt;
  always_ff @(posedge clk) begin
    if (rst || accept) a_cnt <= '0;
    else if (a_en)     a_cnt <= a_cnt + CW'(1);
  end

  AST_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_en, b_en, c_en})); // R2
  AST_CLK_GAP: assert property (@(posedge clk) disable iff (rst)
    (a_en || b_en || c_en) |=> !(a_en || b_en || c_en)); // R3
  AST_PO_QUIET: assert property (@(posedge clk) disable iff (rst)
    po_sample |-> !(a_en || b_en || c_en)); // R5
  AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R8
  AST_A_TOTAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (a_cnt == CW'(2 * N))); // R4

endmodule

// File: rtl/scan_bit_path.sv
module scan_bit_path #(
  parameter int N  = 8,
  parameter int KW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          busy,
  input  logic [N-1:0]  load_pat,
  input  logic          si_load,
  input  logic [KW-1:0] si_idx,
  input  logic          take,
  input  logic          scan_out,
  output logic          scan_in,
  output logic [N-1:0]  unload_pat
);

  logic [N-1:0] pat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q      <= '0;
      scan_in    <= 1'b0;
      unload_pat <= '0;
    end else if (accept) begin
      pat_q      <= load_pat;
      scan_in    <= load_pat[N-1];
      unload_pat <= '0;
    end else begin
      scan_in <= si_load ? pat_q[si_idx] : 1'b0;
      if (take) unload_pat <= {unload_pat[N-2:0], scan_out};
    end
  end

  AST_PAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pat_q)); // R9

endmodule

// File: rtl/latch_pair_chain.sv
module latch_pair_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_en,
  input  logic         b_en,
  input  logic         c_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic         scan_out,
  output logic [N-1:0] slave_q
);

  logic [N-1:0] master;
  logic [N-1:0] shift_src;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign shift_src[gi] = scan_in;
      end else begin : g_body
        assign shift_src[gi] = slave_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      master  <= '0;
      slave_q <= '0;
    end else begin
      if (c_en)      master <= func_d;
      else if (a_en) master <= shift_src;
      if (b_en)      slave_q <= master;
    end
  end

  assign scan_out = slave_q[N-1];

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    c_en |=> (master == $past(func_d))); // R6

endmodule

// File: rtl/scan_clk_seq.sv
module scan_clk_seq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] load_pat,
  input  logic [N-1:0] func_d,
  output logic         a_en,
  output logic         b_en,
  output logic         c_en,
  output logic         pi_apply,
  output logic         po_sample,
  output logic         scan_in,
  output logic         scan_out,
  output logic [N-1:0] slave_q,
  output logic [N-1:0] unload_pat,
  output logic         busy,
  output logic         done
);

  localparam int KW = (N > 1) ? $clog2(N) : 1;

  logic          accept, take, si_load;
  logic [KW-1:0] si_idx;

  scan_step_fsm #(.N(N), .KW(KW)) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .take(take), .si_load(si_load), .si_idx(si_idx),
    .a_en(a_en), .b_en(b_en), .c_en(c_en),
    .pi_apply(pi_apply), .po_sample(po_sample),
    .busy(busy), .done(done)
  );

  scan_bit_path #(.N(N), .KW(KW)) u_bits (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy),
    .load_pat(load_pat), .si_load(si_load), .si_idx(si_idx),
    .take(take), .scan_out(scan_out),
    .scan_in(scan_in), .unload_pat(unload_pat)
  );

  latch_pair_chain #(.N(N)) u_chain (
    .clk(clk), .rst(rst),
    .a_en(a_en), .b_en(b_en), .c_en(c_en),
    .scan_in(scan_in), .func_d(func_d),
    .scan_out(scan_out), .slave_q(slave_q)
  );

endmodule

// File: tb/scan_clk_seq_bench.sv
`timescale 1ns/1ps
module scan_clk_seq_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] load_pat = '0;
  logic [N-1:0] func_d = '0;
  logic         a_en, b_en, c_en, pi_apply, po_sample;
  logic         scan_in, scan_out, busy, done;
  logic [N-1:0] slave_q, unload_pat;

  int total = 0;
  int fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  scan_clk_seq #(.N(N)) u_scan_clk_seq (
    .clk(clk), .rst(rst), .start(start), .load_pat(load_pat), .func_d(func_d),
    .a_en(a_en), .b_en(b_en), .c_en(c_en), .pi_apply(pi_apply),
    .po_sample(po_sample), .scan_in(scan_in), .scan_out(scan_out),
    .slave_q(slave_q), .unload_pat(unload_pat), .busy(busy), .done(done)
  );

  function automatic int exp_busy_len(input int n);
    return 8 * n + 8;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [N-1:0] pat, input logic [N-1:0] fd, input bit poke);
    int cyc = 0;
    int na = 0, nb = 0, nc = 0, npi = 0, npo = 0, nbusy = 0;
    bit prev_clk = 0, overlap = 0, gapbad = 0, order_bad = 0, fin = 0;
    logic [N-1:0] slv_po = '0;
    load_pat = pat;
    func_d   = fd;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 2000) begin
      if ((32'(a_en) + 32'(b_en) + 32'(c_en)) > 1) overlap = 1;
      if (prev_clk && (a_en || b_en || c_en)) gapbad = 1;
      prev_clk = a_en || b_en || c_en;
      if (a_en) na++;
      if (b_en) nb++;
      if (c_en) begin
        nc++;
        if (npo == 0) order_bad = 1;
      end
      if (pi_apply) npi++;
      if (po_sample) begin
        npo++;
        slv_po = slave_q;
        if (a_en || b_en || c_en) order_bad = 1;
      end
      if (busy) nbusy++;
      if (done) begin
        fin = 1;
        chk("R7 response word", 64'(unload_pat), 64'(fd));
        chk("R7 slaves cleared", 64'(slave_q), 64'd0);
        chk("R8 busy low at done", 64'(busy), 64'd0);
      end
      if (poke && cyc == 5) begin
        start = 1'b1;
        load_pat = ~pat;
      end
      if (poke && cyc == 6) start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    chk("R8 done seen", 64'(fin), 64'd1);
    chk("R8 done single cycle", 64'(done), 64'd0);
    chk("R8 busy length", 64'(nbusy), 64'(exp_busy_len(N)));
    chk("R2 clock overlap", 64'(overlap), 64'd0);
    chk("R3 idle gap", 64'(gapbad), 64'd0);
    chk("R4 A pulses", 64'(na), 64'(2 * N));
    chk("R6 B pulses", 64'(nb), 64'(2 * N + 1));
    chk("R6 C pulses", 64'(nc), 64'd1);
    chk("R6 order", 64'(order_bad), 64'd0);
    chk("R5 apply strobes", 64'(npi), 64'd1);
    chk("R5 measure strobes", 64'(npo), 64'd1);
    chk("R4 loaded pattern", 64'(slv_po), 64'(pat));
    if (poke) begin
      chk("R9 ignored start length", 64'(nbusy), 64'(exp_busy_len(N)));
      chk("R9 ignored start pattern", 64'(slv_po), 64'(pat));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p, f;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 clocks in reset", 64'({a_en, b_en, c_en}), 64'd0);
    chk("R1 flags in reset", 64'({busy, done, pi_apply, po_sample, scan_in}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 slaves after reset", 64'(slave_q), 64'd0);
    chk("R1 response after reset", 64'(unload_pat), 64'd0);
    chk("R1 idle after reset", 64'({busy, done, a_en, b_en, c_en}), 64'd0);

    run_one('0, '1, 1'b0);
    run_one('1, '0, 1'b0);
    run_one({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b0);
    for (int w = 0; w < N; w += 3) begin
      p = '0;
      p[w] = 1'b1;
      run_one(p, ~p, 1'b0);
    end
    run_one({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b1);
    repeat (2) @(negedge clk);
    for (int r = 0; r < 12; r++) begin
      p = N'($urandom);
      f = N'($urandom);
      run_one(p, f, (r % 4) == 1);
    end
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

endmodule